// File: doc/BRIEF.md
# PS/2 Host Controller Register Interface

This block is the register front end of a single keyboard or mouse port. A processor reaches it through a word-addressed read/write bus that covers a 4 KB window. On the other side it talks to a byte-level device link: received bytes arrive on a valid/ready stream, and transmitted bytes leave on a valid-only stream. The serial clock/data wire protocol is handled elsewhere. The two line levels are brought in only so that software can observe them.

The block keeps a control register, a clock-divisor register and the last byte popped from the receive stream. From these and from the link inputs it builds a status word and an interrupt-status word, and it drives one level-sensitive interrupt. Eight read-only identification bytes sit at the top of the window, one byte per word.

Bus reads are registered. The bus presents `bus_sel` with `bus_wr` low for one cycle. In the next cycle `bus_rvalid` pulses and `bus_rdata` holds the result. Writes take effect at the clock edge that ends the access cycle.

Back-pressure rules:
- Receive stream: `rx_valid` doubles as the pending flag. The block accepts a byte only by raising `rx_ready`, and it does so only in the cycle of a data-register read.
- Transmit stream: the stream has no ready signal. The sink must take every `tx_valid` pulse.

Top module: `ps2_host_regif`

## Requirements
- R1: After reset:
  - `irq`, `bus_rvalid`, `tx_valid` and `bad_access` are 0.
  - The control register, the divisor register and the last received byte are 0.
- R2: A read access (`bus_sel`=1, `bus_wr`=0) yields `bus_rvalid`=1 with the result on `bus_rdata` in the following cycle. `bus_rvalid` is 0 in every cycle that does not follow a read.
- R3: The status word (word index 1, byte offset 0x004) has these bits:
  - bit 6 is always 1 (transmit empty);
  - bits 5 and 3 are always 0;
  - bit 4 equals `rx_valid`;
  - bit 2 is the receive parity;
  - bit 1 equals `line_clk`;
  - bit 0 equals `line_dat`;
  - all other bits are 0.
- R4: The receive parity bit is 1 when the last received byte holds an odd number of ones, and 0 otherwise.
- R5: A read of the data word (word index 2, offset 0x008) works as follows:
  - `rx_ready` is 1 in the access cycle, and only then.
  - If `rx_valid` is 1, the byte on `rx_data` is returned and becomes the last byte.
  - If `rx_valid` is 0, the last byte is returned unchanged.
- R6: `irq` = (`rx_valid` AND control bit 4) OR control bit 3. It is combinational, so it changes in the cycle after a control write and whenever `rx_valid` changes.
- R7: The interrupt-status word (word index 4, offset 0x010) reads `rx_valid` in bit 0 and a constant 1 in bit 1. All other bits are 0.
- R8: A write to the data word puts the low 8 bits of `bus_wdata` on `tx_data`, with `tx_valid`=1 for exactly the next cycle.
- R9: The control word (index 0) and the divisor word (index 3) store the low 8 bits written and read them back. The upper bits read as 0.
- R10: Reads at byte offsets 0xFE0 to 0xFFC return the identification bytes, one per word, in this order: 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to these offsets change nothing.
- R11: Any other word index has these effects:
  - a read returns 0;
  - a write changes no register;
  - `bad_access` is 1 for exactly the cycle after the access.
- R12: Byte-offset bits [1:0] are ignored when a register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read result valid, one cycle after a read |
| bus_rdata | output | 32 | Read result |
| bad_access | output | 1 | Pulse after an access to an unmapped word |
| rx_valid | input | 1 | Receive byte pending |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte accepted (data-word read) |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| line_clk | input | 1 | Observed clock-line level |
| line_dat | input | 1 | Observed data-line level |
| irq | output | 1 | Level interrupt |

## Verification
The case of interest is a control write that lands in the same cycle as a change in receive pending. In that cycle the stored enable and the pending flag both move, and the interrupt has to merge the two correctly. The bench raises `rx_valid` in the same cycle as a control write that sets the receive-interrupt enable. It then checks `irq` in the following cycle, and checks it again after the pending byte is popped by a data read. A second collision comes from reading the data word while a byte is pending. Here the pop, the latching of the new last byte and the parity bit must all agree. The bench judges this by reading status right after the pop.

// File: rtl/ps2rif_pkg.sv
package ps2rif_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STAT,
    SEL_DATA,
    SEL_DIV,
    SEL_ISR,
    SEL_ID,
    SEL_NONE
  } regsel_e;

  // Identification bytes, word order from the bottom of the ID area.
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h50;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ps2rif_decode.sv
module ps2rif_decode
  import ps2rif_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic [WORD_W-1:0] word,
  output regsel_e           sel,
  output logic [2:0]        id_idx
);
  localparam int NWORDS  = 1 << WORD_W;
  localparam int ID_BASE = NWORDS - 8;

  always_comb begin
    id_idx = word[2:0];
    if (word >= WORD_W'(ID_BASE)) begin
      sel = SEL_ID;
    end else begin
      case (word)
        WORD_W'(0): sel = SEL_CTRL;
        WORD_W'(1): sel = SEL_STAT;
        WORD_W'(2): sel = SEL_DATA;
        WORD_W'(3): sel = SEL_DIV;
        WORD_W'(4): sel = SEL_ISR;
        default:    sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ps2rif_parity.sv
// XOR reduction by repeated halving (fold by W/2, W/4, ... 1).
module ps2rif_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  output logic         odd
);
  localparam int STAGES = $clog2(W);

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    localparam int HW = W >> (s + 1);
    logic [HW-1:0] v;
    if (s == 0) begin : g_first
      assign v = d[2*HW-1:HW] ^ d[HW-1:0];
    end else begin : g_next
      assign v = g_st[s-1].v[2*HW-1:HW] ^ g_st[s-1].v[HW-1:0];
    end
  end

  assign odd = g_st[STAGES-1].v[0];
endmodule

// File: rtl/ps2rif_rxlatch.sv
module ps2rif_rxlatch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic [BYTE_W-1:0] pop_byte,
  output logic [BYTE_W-1:0] last_q,
  output logic              last_odd
);
  assign pop_byte = rx_valid ? rx_data : last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= '0;
    else if (pop) last_q <= pop_byte;
  end

  ps2rif_parity #(.W(BYTE_W)) par_i (.d(last_q), .odd(last_odd));
endmodule

// File: rtl/ps2_host_regif.sv
module ps2_host_regif
  import ps2rif_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              bus_rvalid,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bad_access,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              line_clk,
  input  logic              line_dat,
  output logic              irq
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int RXIE_BIT = 4;
  localparam int TXIE_BIT = 3;
  localparam int W_A      = (CTRL_W > DIV_W) ? CTRL_W : DIV_W;
  localparam int W_USED   = (W_A > BYTE_W) ? W_A : BYTE_W;

  regsel_e           sel;
  logic [2:0]        id_idx;
  logic              rd_acc, wr_acc;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [BYTE_W-1:0] pop_byte, last_q;
  logic              last_odd;
  logic [BUS_W-1:0]  status_w, isr_w, rd_mux;
  logic              unused_bus_bits;

  assign unused_bus_bits = ^{bus_wdata[BUS_W-1:W_USED], bus_addr[1:0]};

  ps2rif_decode #(.WORD_W(WORD_W)) dec_i (
    .word(bus_addr[ADDR_W-1:2]), .sel(sel), .id_idx(id_idx)
  );

  assign rd_acc   = bus_sel & ~bus_wr;
  assign wr_acc   = bus_sel & bus_wr;
  assign rx_ready = rd_acc && (sel == SEL_DATA);

  ps2rif_rxlatch #(.BYTE_W(BYTE_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .pop(rx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .pop_byte(pop_byte), .last_q(last_q), .last_odd(last_odd)
  );

  // Transmit is taken in one cycle, so it is always empty and never busy.
  always_comb begin
    status_w    = '0;
    status_w[6] = 1'b1;
    status_w[5] = 1'b0;
    status_w[4] = rx_valid;
    status_w[3] = 1'b0;
    status_w[2] = last_odd;
    status_w[1] = line_clk;
    status_w[0] = line_dat;
    isr_w       = '0;
    isr_w[1]    = 1'b1;
    isr_w[0]    = rx_valid;
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = BUS_W'(ctrl_q);
      SEL_STAT: rd_mux = status_w;
      SEL_DATA: rd_mux = BUS_W'(pop_byte);
      SEL_DIV:  rd_mux = BUS_W'(div_q);
      SEL_ISR:  rd_mux = isr_w;
      SEL_ID:   rd_mux = BUS_W'(id_byte(id_idx));
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      bad_access <= 1'b0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      ctrl_q     <= '0;
      div_q      <= '0;
    end else begin
      bus_rvalid <= rd_acc;
      if (rd_acc) bus_rdata <= rd_mux;
      bad_access <= bus_sel && (sel == SEL_NONE);
      tx_valid   <= wr_acc && (sel == SEL_DATA);
      if (wr_acc && sel == SEL_DATA) tx_data <= bus_wdata[BYTE_W-1:0];
      if (wr_acc && sel == SEL_CTRL) ctrl_q  <= bus_wdata[CTRL_W-1:0];
      if (wr_acc && sel == SEL_DIV)  div_q   <= bus_wdata[DIV_W-1:0];
    end
  end

  assign irq = (rx_valid & ctrl_q[RXIE_BIT]) | ctrl_q[TXIE_BIT];
endmodule

// File: rtl/ps2rif_chk.sv
module ps2rif_chk #(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  parameter int BUS_W  = 32,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_rvalid,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              bad_access,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              irq
);
  logic [ADDR_W-3:0] word;
  assign word = bus_addr[ADDR_W-1:2];

  a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);
  a_r2_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);
  a_r5_pop_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (bus_sel && !bus_wr));
  a_r8_tx_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && word == 2) |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));
  a_r6_txie_forces_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[3] |-> irq);
  a_r6_rx_pending_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[4] && rx_valid) |-> irq);
  a_r7_isr_bit1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && word == 4) |=> bus_rdata[1]);
  a_r11_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && word == 5) |=> bad_access);
endmodule

bind ps2_host_regif ps2rif_chk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BUS_W(BUS_W), .CTRL_W(CTRL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .bus_rdata(bus_rdata), .bad_access(bad_access), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
  .ctrl_q(ctrl_q), .irq(irq)
);

// File: tb/ps2_host_regif_tb.sv
`timescale 1ns/1ps
module ps2_host_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid, bad_access, rx_ready, tx_valid, irq;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [7:0]  tx_data;
  logic        line_clk = 1'b1, line_dat = 1'b1;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ps2_host_regif dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .bad_access(bad_access), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .line_clk(line_clk), .line_dat(line_dat), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus access; returns at the negedge after the capturing edge.
  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // {wr, addr, wdata, rx_valid, rx_data, expected read}
  localparam int NV = 18;
  localparam logic [85:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'h0000_01A5, 1'b0, 8'h00, 32'h0},           // R9
    {1'b0, 12'h000, 32'h0,         1'b0, 8'h00, 32'h0000_00A5},   // R9
    {1'b1, 12'h00C, 32'hFFFF_FF3C, 1'b0, 8'h00, 32'h0},           // R9
    {1'b0, 12'h00C, 32'h0,         1'b0, 8'h00, 32'h0000_003C},   // R9
    {1'b0, 12'h004, 32'h0,         1'b0, 8'h00, 32'h0000_0043},   // R3
    {1'b0, 12'h008, 32'h0,         1'b1, 8'h07, 32'h0000_0007},   // R5
    {1'b0, 12'h004, 32'h0,         1'b0, 8'h00, 32'h0000_0047},   // R4 odd
    {1'b0, 12'h004, 32'h0,         1'b1, 8'h99, 32'h0000_0057},   // R3 pending
    {1'b0, 12'h008, 32'h0,         1'b1, 8'h99, 32'h0000_0099},   // R5
    {1'b0, 12'h004, 32'h0,         1'b0, 8'h00, 32'h0000_0043},   // R4 even
    {1'b0, 12'h010, 32'h0,         1'b1, 8'h00, 32'h0000_0003},   // R7
    {1'b0, 12'h010, 32'h0,         1'b0, 8'h00, 32'h0000_0002},   // R7
    {1'b0, 12'hFE0, 32'h0,         1'b0, 8'h00, 32'h0000_0050},   // R10
    {1'b0, 12'hFEC, 32'h0,         1'b0, 8'h00, 32'h0000_0000},   // R10
    {1'b0, 12'hFF4, 32'h0,         1'b0, 8'h00, 32'h0000_00F0},   // R10
    {1'b0, 12'hFFC, 32'h0,         1'b0, 8'h00, 32'h0000_00B1},   // R10
    {1'b0, 12'h008, 32'h0,         1'b0, 8'h00, 32'h0000_0099},   // R5 empty
    {1'b0, 12'h006, 32'h0,         1'b0, 8'h00, 32'h0000_0043}    // R12
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 irq", 32'(irq), 0);
    check("R1 rvalid", 32'(bus_rvalid), 0);
    check("R1 tx_valid", 32'(tx_valid), 0);
    rst_n = 1'b1;
    access(1'b0, 12'h000, 0); check("R1 ctrl", bus_rdata, 0);
    access(1'b0, 12'h00C, 0); check("R1 div", bus_rdata, 0);
    access(1'b0, 12'h004, 0); check("R1 parity of last", 32'(bus_rdata[2]), 0);

    for (int i = 0; i < NV; i++) begin
      rx_valid = VEC[i][40];
      rx_data  = VEC[i][39:32];
      access(VEC[i][85], VEC[i][84:73], VEC[i][72:41]);
      if (!VEC[i][85]) begin
        check($sformatf("R2 rvalid vec%0d", i), 32'(bus_rvalid), 1);
        check($sformatf("R3/R4/R5/R7/R9/R10/R12 vec%0d", i), bus_rdata, VEC[i][31:0]);
      end
    end
    rx_valid = 1'b0;
    @(negedge clk);
    check("R2 no rvalid when idle", 32'(bus_rvalid), 0);

    // R5: ready only during a data read
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h3C;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h004;
    #1 check("R5 no pop on status read", 32'(rx_ready), 0);
    @(negedge clk);
    bus_addr = 12'h008;
    #1 check("R5 pop on data read", 32'(rx_ready), 1);
    @(negedge clk);
    bus_sel = 1'b0;
    check("R5 popped byte", bus_rdata, 32'h3C);
    rx_valid = 1'b0;

    // R6 interrupt
    access(1'b1, 12'h000, 32'h08);
    #1 check("R6 tx enable irq", 32'(irq), 1);
    access(1'b1, 12'h000, 32'h10);
    #1 check("R6 rx enable no pending", 32'(irq), 0);
    rx_valid = 1'b1;
    #1 check("R6 rx enable pending", 32'(irq), 1);
    rx_valid = 1'b0;
    access(1'b1, 12'h000, 32'h00);
    // collision: control write and pending rise in one cycle
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h10;
    rx_valid = 1'b1; rx_data = 8'h01;
    #1 check("R6 before edge", 32'(irq), 0);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R6 after collision", 32'(irq), 1);
    access(1'b0, 12'h008, 0);
    check("R5 collision pop", bus_rdata, 32'h01);
    rx_valid = 1'b0;
    #1 check("R6 drop after pop", 32'(irq), 0);
    access(1'b0, 12'h004, 0);
    check("R4 parity after pop", 32'(bus_rdata[2]), 1);

    // R8 transmit
    access(1'b1, 12'h008, 32'h1234_56C3);
    check("R8 tx_valid", 32'(tx_valid), 1);
    check("R8 tx_data", 32'(tx_data), 32'hC3);
    @(negedge clk);
    check("R8 single pulse", 32'(tx_valid), 0);

    // R11 unmapped
    access(1'b1, 12'h020, 32'hFF);
    check("R11 write flag", 32'(bad_access), 1);
    @(negedge clk);
    check("R11 flag one cycle", 32'(bad_access), 0);
    access(1'b0, 12'h000, 0);
    check("R11 ctrl unchanged", bus_rdata, 32'h10);
    access(1'b0, 12'h014, 0);
    check("R11 read zero", bus_rdata, 0);
    check("R11 read flag", 32'(bad_access), 1);
    access(1'b1, 12'hFE0, 32'h77);
    check("R10 id write no flag", 32'(bad_access), 0);
    access(1'b0, 12'hFE0, 0);
    check("R10 id unchanged", bus_rdata, 32'h50);

    // R3 line levels
    line_clk = 1'b0; line_dat = 1'b1;
    access(1'b0, 12'h004, 0);
    check("R3 line bits", 32'(bus_rdata[1:0]), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule